// File: doc/BRIEF.md
# Skewed Source Word Aligner

This block feeds a bit-block transfer engine with source data that is aligned to destination word boundaries. For every destination word it produces one 16-bit source word, taken as a window from a 32-bit two-word shift buffer. The buffer is filled by word-wide memory reads, and the window is shifted right by a programmable skew of 0 to 15 bits. The block walks a rectangle of `words x lines` destination words. It steps the source address by a horizontal step inside a line and by a vertical step after the last source word of each line. Either step direction is supported, and the sign of the horizontal step also sets the direction in which the buffer shifts.

A control byte carries two per-line fetch modifiers, `lead` and `skip`:

- `lead` adds an extra read before the first word of each line, which primes the buffer.
- `skip` drops the read for the last word of each line, so the buffer only shifts.

Reads go out as a request/acknowledge pair, and the buffer changes only when a read is acknowledged. Each aligned word is held on a valid/ready output until the consumer takes it. Logic operations and destination writes are outside this block.

The state machine has six states:

- **S_IDLE**: waits for `start`.
- **S_WORD**: decides the fetch pattern for the next destination word.
- **S_LEAD**: performs the extra first read.
- **S_MAIN**: performs the normal shift and read.
- **S_SHIFT**: shifts the buffer without reading.
- **S_OUT**: presents the aligned word.

The transitions are:

| From | Condition | To |
|---|---|---|
| S_IDLE | `start` | S_WORD |
| S_WORD | first word of the line and `lead` set | S_LEAD |
| S_WORD | otherwise, last word of the line and `skip` set | S_SHIFT |
| S_WORD | otherwise | S_MAIN |
| S_LEAD | `rd_ack` | S_SHIFT or S_MAIN, by the same last-word/`skip` test |
| S_MAIN | `rd_ack` | S_OUT |
| S_SHIFT | always | S_OUT |
| S_OUT | `out_ready`, last word of the last line | S_IDLE |
| S_OUT | `out_ready`, otherwise | S_WORD |

Top module: `skew_align`

## Requirements
- R1: After reset `busy`, `rd_req` and `out_valid` are 0. A `start` in S_IDLE latches all `cfg_*` inputs. A `start` while busy is ignored, and later `cfg_*` changes do not affect the running transfer.
- R2: When bit 15 of the horizontal step is 0, every read first shifts the 32-bit buffer left by 16 and places the read word in bits 15:0.
- R3: When bit 15 of the horizontal step is 1, every read first shifts the buffer right by 16 and places the read word in bits 31:16.
- R4: `out_word` equals bits 15:0 of the buffer shifted right by `cfg_ctrl[3:0]`, taken after the fetch for that destination word.
- R5: When `cfg_ctrl[7]` (`lead`) is 1, the first destination word of every line is preceded by one extra shift-and-read.
- R6: When `cfg_ctrl[6]` (`skip`) is 1, the last destination word of every line only shifts the buffer and issues no read. A one-word line applies both `lead` and `skip`, and middle words apply neither.
- R7: Source words per line are words + `lead` − `skip`, and this count is reloaded at each line start. After a read the address adds the sign-extended horizontal step, except after the line's last source word, where it adds the vertical step. Bit 0 of the address and of both steps is forced to 0.
- R8: When `cfg_narrow` is 1, the address bits above bit 23 are held at 0, both when it is loaded and after every step.
- R9: `rd_req` stays high with `rd_addr` stable until `rd_ack`. The buffer is updated only on a cycle with `rd_req` and `rd_ack` both high.
- R10: Each destination word yields exactly one output, held with a stable `out_word` until `out_ready`. `rd_req` and `out_valid` are never high together. After words × lines outputs `busy` falls.
- R11: A `cfg_words` or `cfg_lines` value of 0 means 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer; latches the configuration |
| cfg_ctrl | input | 8 | Bit 7 `lead`, bit 6 `skip`, bits 3:0 skew |
| cfg_x_step | input | STEP_W | Signed horizontal source step |
| cfg_y_step | input | STEP_W | Signed vertical (end-of-line) source step |
| cfg_addr | input | ADDR_W | Initial source address |
| cfg_narrow | input | 1 | Restrict addresses to 24 bits |
| cfg_words | input | CNT_W | Destination words per line (0 = 2^CNT_W) |
| cfg_lines | input | CNT_W | Lines per transfer (0 = 2^CNT_W) |
| busy | output | 1 | Transfer in progress |
| rd_req | output | 1 | Read request |
| rd_addr | output | ADDR_W | Read address |
| rd_ack | input | 1 | Read acknowledge; `rd_data` is valid |
| rd_data | input | WORD_W | Read data |
| out_valid | output | 1 | Aligned word available |
| out_ready | input | 1 | Consumer takes the aligned word |
| out_word | output | WORD_W | Aligned source word |

## Verification
The `lead` read and the end-of-line vertical step can fall on the same read. This happens on a one-word line with both `lead` and `skip` set, where the count of source words per line is 1. That single extra read is then the last source word of the line, so the address must take the vertical step at once. The bench provokes this with a three-line run of one-word lines. It judges the result by comparing every issued read address, including the first read of each following line, against its own model.

// File: rtl/skew_align_pkg.sv
package skew_align_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WORD,
        S_LEAD,
        S_MAIN,
        S_SHIFT,
        S_OUT
    } sa_state_t;

    localparam int CTRL_LEAD_BIT = 7;
    localparam int CTRL_SKIP_BIT = 6;

endpackage

// File: rtl/sa_shift_buf.sv
module sa_shift_buf #(
    parameter int WORD_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load_cfg,
    input  logic                      cfg_desc,
    input  logic [$clog2(WORD_W)-1:0] cfg_skew,
    input  logic                      push,
    input  logic [WORD_W-1:0]         push_data,
    input  logic                      shift_only,
    output logic [WORD_W-1:0]         word_out
);
    localparam int BUF_W  = 2 * WORD_W;
    localparam int SKEW_W = $clog2(WORD_W);

    logic              desc_q;
    logic [SKEW_W-1:0] skew_q;
    logic [BUF_W-1:0]  buf_q;
    logic [BUF_W-1:0]  shifted;
    logic [BUF_W-1:0]  entry;
    logic [BUF_W-1:0]  window;

    always_comb begin
        shifted = desc_q ? (buf_q >> WORD_W) : (buf_q << WORD_W);
        entry   = desc_q ? {push_data, {WORD_W{1'b0}}} : {{WORD_W{1'b0}}, push_data};
        window  = buf_q >> skew_q;
    end

    assign word_out = window[WORD_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            desc_q <= 1'b0;
            skew_q <= '0;
            buf_q  <= '0;
        end else begin
            if (load_cfg) begin
                desc_q <= cfg_desc;
                skew_q <= cfg_skew;
            end
            if (push) begin
                buf_q <= shifted | entry;
            end else if (shift_only) begin
                buf_q <= shifted;
            end
        end
    end

    // R2: ascending reads land in the low half
    a_r2_low_entry: assert property (@(posedge clk) disable iff (!rst_n)
        push && !desc_q |=> buf_q[WORD_W-1:0] == $past(push_data));

    // R3: descending reads land in the high half
    a_r3_high_entry: assert property (@(posedge clk) disable iff (!rst_n)
        push && desc_q |=> buf_q[BUF_W-1:WORD_W] == $past(push_data));

    // R9: buffer holds when neither a read nor a plain shift happens
    a_r9_buf_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !push && !shift_only |=> $stable(buf_q));

endmodule

// File: rtl/sa_addr_step.sv
module sa_addr_step #(
    parameter int ADDR_W   = 32,
    parameter int STEP_W   = 16,
    parameter int NARROW_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_cfg,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [STEP_W-1:0] cfg_x_step,
    input  logic [STEP_W-1:0] cfg_y_step,
    input  logic              cfg_narrow,
    input  logic              step,
    input  logic              use_y,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] WIDE_MASK   = ~ADDR_W'(1);
    localparam logic [ADDR_W-1:0] NARROW_MASK = WIDE_MASK & ((ADDR_W'(1) << NARROW_W) - ADDR_W'(1));

    logic [ADDR_W-1:0] x_q, y_q, addr_q, mask_q;
    logic [ADDR_W-1:0] mask_in;

    function automatic logic [ADDR_W-1:0] sext_even(input logic [STEP_W-1:0] s);
        logic [STEP_W-1:0] e;
        e = s & ~STEP_W'(1);
        return {{(ADDR_W-STEP_W){e[STEP_W-1]}}, e};
    endfunction

    assign mask_in = cfg_narrow ? NARROW_MASK : WIDE_MASK;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_q    <= '0;
            y_q    <= '0;
            addr_q <= '0;
            mask_q <= WIDE_MASK;
        end else if (load_cfg) begin
            x_q    <= sext_even(cfg_x_step);
            y_q    <= sext_even(cfg_y_step);
            addr_q <= cfg_addr & mask_in;
            mask_q <= mask_in;
        end else if (step) begin
            addr_q <= (addr_q + (use_y ? y_q : x_q)) & mask_q;
        end
    end

    assign addr = addr_q;

    // R7: address stays even
    a_r7_even_addr: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_q[0]);

    // R8: narrow mode keeps the upper address bits clear
    a_r8_narrow_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == NARROW_MASK) |-> ((addr_q & ~NARROW_MASK) == '0));

    // R7: address moves only on a read
    a_r7_step_only_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        !step && !load_cfg |=> $stable(addr_q));

endmodule

// File: rtl/sa_ctrl.sv
module sa_ctrl
    import skew_align_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cfg_lead,
    input  logic             cfg_skip,
    input  logic [CNT_W-1:0] cfg_words,
    input  logic [CNT_W-1:0] cfg_lines,
    input  logic             rd_ack,
    input  logic             out_ready,
    output logic             load_cfg,
    output logic             busy,
    output logic             rd_req,
    output logic             fetch,
    output logic             shift_only,
    output logic             use_y,
    output logic             out_valid
);
    localparam int TOT_W = CNT_W + 1;
    localparam int SRC_W = CNT_W + 2;

    sa_state_t         state, state_nx;
    logic              lead_q, skip_q;
    logic [TOT_W-1:0]  words_q, dst_left, lines_left;
    logic [SRC_W-1:0]  src_left;
    logic              first_w, last_w, last_line, out_fire;

    function automatic logic [TOT_W-1:0] total_of(input logic [CNT_W-1:0] v);
        return (v == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, v};
    endfunction

    assign first_w   = (dst_left == words_q);
    assign last_w    = (dst_left == TOT_W'(1));
    assign last_line = (lines_left == TOT_W'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (start) state_nx = S_WORD;
            S_WORD: begin
                if (first_w && lead_q)      state_nx = S_LEAD;
                else if (last_w && skip_q)  state_nx = S_SHIFT;
                else                        state_nx = S_MAIN;
            end
            S_LEAD:  if (rd_ack) state_nx = (last_w && skip_q) ? S_SHIFT : S_MAIN;
            S_MAIN:  if (rd_ack) state_nx = S_OUT;
            S_SHIFT: state_nx = S_OUT;
            S_OUT:   if (out_ready) state_nx = (last_w && last_line) ? S_IDLE : S_WORD;
            default: state_nx = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load_cfg   = (state == S_IDLE) && start;
        busy       = (state != S_IDLE);
        rd_req     = (state == S_LEAD) || (state == S_MAIN);
        fetch      = rd_req && rd_ack;
        shift_only = (state == S_SHIFT);
        out_valid  = (state == S_OUT);
        use_y      = (src_left == SRC_W'(1));
        out_fire   = out_valid && out_ready;
    end

    // counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lead_q     <= 1'b0;
            skip_q     <= 1'b0;
            words_q    <= TOT_W'(1);
            dst_left   <= TOT_W'(1);
            lines_left <= TOT_W'(1);
            src_left   <= '0;
        end else begin
            if (load_cfg) begin
                lead_q     <= cfg_lead;
                skip_q     <= cfg_skip;
                words_q    <= total_of(cfg_words);
                dst_left   <= total_of(cfg_words);
                lines_left <= total_of(cfg_lines);
            end
            if (state == S_WORD && first_w) begin
                src_left <= SRC_W'(words_q) + SRC_W'(lead_q) - SRC_W'(skip_q);
            end else if (fetch && !use_y) begin
                src_left <= src_left - SRC_W'(1);
            end
            if (out_fire) begin
                if (last_w) begin
                    dst_left   <= words_q;
                    lines_left <= lines_left - TOT_W'(1);
                end else begin
                    dst_left <= dst_left - TOT_W'(1);
                end
            end
        end
    end

    // R10: never asks for data and offers a result at once
    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && out_valid));

    // R1: idle means quiet ports
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !rd_req && !out_valid);

    // R1: a start while busy leaves the latched setup alone
    a_r1_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start |=> $stable(words_q) && $stable(lead_q) && $stable(skip_q));

    // R7: source count never exceeds its per-line reload value
    a_r7_src_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> src_left <= SRC_W'(words_q) + SRC_W'(1));

endmodule

// File: rtl/skew_align.sv
module skew_align
    import skew_align_pkg::*;
#(
    parameter int WORD_W   = 16,
    parameter int ADDR_W   = 32,
    parameter int STEP_W   = 16,
    parameter int NARROW_W = 24,
    parameter int CNT_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        cfg_ctrl,
    input  logic [STEP_W-1:0] cfg_x_step,
    input  logic [STEP_W-1:0] cfg_y_step,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              cfg_narrow,
    input  logic [CNT_W-1:0]  cfg_words,
    input  logic [CNT_W-1:0]  cfg_lines,
    output logic              busy,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ack,
    input  logic [WORD_W-1:0] rd_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_word
);
    localparam int SKEW_W = $clog2(WORD_W);

    logic load_cfg, fetch, shift_only, use_y;
    logic unused_ctrl_bits;

    assign unused_ctrl_bits = ^cfg_ctrl[5:SKEW_W];

    sa_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .cfg_lead   (cfg_ctrl[CTRL_LEAD_BIT]),
        .cfg_skip   (cfg_ctrl[CTRL_SKIP_BIT]),
        .cfg_words  (cfg_words),
        .cfg_lines  (cfg_lines),
        .rd_ack     (rd_ack),
        .out_ready  (out_ready),
        .load_cfg   (load_cfg),
        .busy       (busy),
        .rd_req     (rd_req),
        .fetch      (fetch),
        .shift_only (shift_only),
        .use_y      (use_y),
        .out_valid  (out_valid)
    );

    sa_shift_buf #(.WORD_W(WORD_W)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_cfg   (load_cfg),
        .cfg_desc   (cfg_x_step[STEP_W-1]),
        .cfg_skew   (cfg_ctrl[SKEW_W-1:0]),
        .push       (fetch),
        .push_data  (rd_data),
        .shift_only (shift_only),
        .word_out   (out_word)
    );

    sa_addr_step #(.ADDR_W(ADDR_W), .STEP_W(STEP_W), .NARROW_W(NARROW_W)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_cfg   (load_cfg),
        .cfg_addr   (cfg_addr),
        .cfg_x_step (cfg_x_step),
        .cfg_y_step (cfg_y_step),
        .cfg_narrow (cfg_narrow),
        .step       (fetch),
        .use_y      (use_y),
        .addr       (rd_addr)
    );

    // R9: request holds its address until acknowledged
    a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rd_ack |=> rd_req && $stable(rd_addr));

    // R10: offered word is held until taken
    a_r10_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_word));

endmodule

// File: tb/skew_align_bench.sv
module skew_align_bench;
    localparam int CW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  cfg_ctrl = '0;
    logic [15:0] cfg_x_step = '0, cfg_y_step = '0;
    logic [31:0] cfg_addr = '0;
    logic        cfg_narrow = 1'b0;
    logic [CW-1:0] cfg_words = '0, cfg_lines = '0;
    logic        busy, rd_req, rd_ack = 1'b0, out_valid, out_ready = 1'b0;
    logic [31:0] rd_addr;
    logic [15:0] rd_data = '0, out_word;

    int n_chk = 0, n_bad = 0, cycles = 0;
    logic [15:0] exp_words[$];
    logic [31:0] exp_addrs[$];
    string       tag_w = "R4", tag_a = "R7";
    logic [31:0] mb = '0;
    logic [15:0] lfsr = 16'hACE1;

    skew_align #(.CNT_W(CW)) u_skew_align (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_ctrl(cfg_ctrl),
        .cfg_x_step(cfg_x_step), .cfg_y_step(cfg_y_step), .cfg_addr(cfg_addr),
        .cfg_narrow(cfg_narrow), .cfg_words(cfg_words), .cfg_lines(cfg_lines),
        .busy(busy), .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack),
        .rd_data(rd_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_word(out_word)
    );

    always #10 clk = ~clk;

    function automatic logic [15:0] word_at(input logic [31:0] a);
        return a[16:1] ^ {a[24:17], a[8:1]} ^ 16'h3C5A ^ {a[31:24], a[31:24]};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary_and_end();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=done", cycles);
            summary_and_end();
        end
    end

    // responder and monitor: drive handshakes at the falling edge, score each fire
    initial begin
        forever begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            rd_ack  = rst_n && rd_req && (lfsr[0] | lfsr[1]);
            rd_data = word_at(rd_addr);
            if (rd_ack) begin
                if (exp_addrs.size() == 0) chk(1'b0, {tag_a, " extra read"}, rd_addr, 32'h0);
                else begin
                    logic [31:0] ea;
                    ea = exp_addrs.pop_front();
                    chk(rd_addr == ea, {tag_a, " read address"}, rd_addr, ea);
                end
            end
            out_ready = lfsr[2] | lfsr[3];
            if (rst_n && out_valid && out_ready) begin
                if (exp_words.size() == 0) chk(1'b0, {tag_w, " extra word"}, {16'h0, out_word}, 32'h0);
                else begin
                    logic [15:0] ew;
                    ew = exp_words.pop_front();
                    chk(out_word == ew, {tag_w, " aligned word"}, {16'h0, out_word}, {16'h0, ew});
                end
            end
        end
    end

    // driver: model the transfer from the requirements, then run it
    task automatic blit(input logic [7:0] ctrl, input logic [15:0] xs, input logic [15:0] ys,
                        input logic [31:0] a, input bit narrow, input int words, input int lines,
                        input string tw, input string ta, input bit poke);
        logic [31:0] msk, ma, xe, ye;
        bit desc, lead, skip;
        int nw, nl, sl;
        msk  = narrow ? 32'h00FF_FFFE : 32'hFFFF_FFFE;
        xe   = {{16{xs[15]}}, xs & 16'hFFFE};
        ye   = {{16{ys[15]}}, ys & 16'hFFFE};
        desc = xs[15]; lead = ctrl[7]; skip = ctrl[6];
        nw   = (words == 0) ? (1 << CW) : words;
        nl   = (lines == 0) ? (1 << CW) : lines;
        ma   = a & msk;
        for (int l = 0; l < nl; l++) begin
            sl = nw + int'(lead) - int'(skip);
            for (int w = 0; w < nw; w++) begin
                int nf;
                nf = 0;
                if (w == 0 && lead) nf++;
                for (int k = 0; k <= nf; k++) begin
                    mb = desc ? (mb >> 16) : (mb << 16);
                    if (k < nf || !(w == nw - 1 && skip)) begin
                        logic [15:0] d;
                        d  = word_at(ma);
                        mb = mb | (desc ? {d, 16'h0} : {16'h0, d});
                        exp_addrs.push_back(ma);
                        if (sl == 1) ma = (ma + ye) & msk;
                        else begin sl--; ma = (ma + xe) & msk; end
                    end
                end
                exp_words.push_back(16'((mb >> ctrl[3:0]) & 32'hFFFF));
            end
        end
        tag_w = tw; tag_a = ta;
        @(negedge clk);
        cfg_ctrl = ctrl; cfg_x_step = xs; cfg_y_step = ys; cfg_addr = a;
        cfg_narrow = narrow; cfg_words = CW'(words); cfg_lines = CW'(lines);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (4) @(negedge clk);
            cfg_ctrl = 8'hC5; cfg_words = CW'(1); cfg_lines = CW'(7);
            cfg_addr = 32'h0000_0400; cfg_x_step = 16'h0040;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(exp_words.size() == 0, {"R10 all words delivered ", tw}, exp_words.size(), 0);
        chk(exp_addrs.size() == 0, {"R10 all reads issued ", ta}, exp_addrs.size(), 0);
        chk(!busy && !rd_req && !out_valid, "R10 idle after transfer", {busy, rd_req, out_valid}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R1 reset busy", busy, 0);
        chk(rd_req == 1'b0, "R1 reset rd_req", rd_req, 0);
        chk(out_valid == 1'b0, "R1 reset out_valid", out_valid, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R2 R4 R7: ascending, skew 5, plain fetches, x and y steps
        blit(8'h05, 16'h0002, 16'h000A, 32'h0000_1000, 1'b0, 3, 2, "R2/R4", "R7", 1'b0);
        // R5: extra first read per line
        blit(8'h87, 16'h0002, 16'h0010, 32'h0000_2000, 1'b0, 4, 2, "R5", "R5/R7", 1'b0);
        // R6: last word shifts only
        blit(8'h4A, 16'h0004, 16'h0020, 32'h0000_3000, 1'b0, 3, 2, "R6", "R6/R7", 1'b0);
        // R6 R7: one-word lines, both flags; lead read takes the y step
        blit(8'hC3, 16'h0002, 16'h0100, 32'h0000_4000, 1'b0, 1, 3, "R6 single", "R7 single", 1'b0);
        // R3: descending traversal with lead
        blit(8'h83, 16'hFFFE, 16'hFFEC, 32'h0000_5100, 1'b0, 3, 2, "R3", "R3/R7", 1'b0);
        // R8 R7: narrow wrap, odd steps and address forced even
        blit(8'h09, 16'h0003, 16'h0101, 32'hABFF_FFFB, 1'b1, 4, 2, "R8", "R8/R7 even", 1'b0);
        // R1: start and config changes while busy are ignored
        blit(8'h8C, 16'h0002, 16'h0006, 32'h0000_6000, 1'b0, 5, 3, "R1 busy start", "R1 busy start", 1'b1);
        // R9: heavy ack/ready backpressure is present throughout; here a one-word, no-flag line
        blit(8'h0F, 16'h0002, 16'h0002, 32'h0000_7000, 1'b0, 1, 4, "R9", "R9", 1'b0);
        // R11: zero words means 2^CNT_W words; zero lines means 2^CNT_W lines
        blit(8'h01, 16'h0002, 16'h0002, 32'h0001_0000, 1'b0, 0, 1, "R11 words", "R11 words", 1'b0);
        blit(8'h42, 16'h0002, 16'h0004, 32'h0002_0000, 1'b0, 2, 0, "R11 lines", "R11 lines", 1'b0);
        summary_and_end();
    end
endmodule